// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a 32-bit virtual address to a physical address by fetching translation descriptors from memory. A translation cache that misses starts a walk by presenting the virtual address and whether the access was an instruction fetch or a data access. The walker forms the first-level descriptor address from a 16KB-aligned table base and the top twelve address bits, issues one word read, and decodes the two type bits of the returned descriptor.

A 1MB section finishes the walk after that single read. A descriptor that points to a coarse second-level table causes a second read into a 256-entry table, and a 4KB small page entry finishes the walk there. Any other encoding ends the walk in a translation fault. The fault is tagged as an instruction abort or a data abort to match the access that missed. A successful result carries the physical address, a flag that tells a section from a page, and the raw final descriptor, so that the requester can refill its cache with the attribute bits unchanged.

The memory side is a single-outstanding word-read master. A read request stays raised with a steady address until the memory answers with a valid strobe. Only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_req_o` and `rsp_valid_o` are 0.
- R2: The first read of a walk is at address {ttb_i[31:14], va[31:20], 2'b00}. Bits ttb_i[13:0] have no effect.
- R3: A first-level descriptor with bits [1:0] = 2'b10 is a section. The walk then makes exactly one read and returns pa = {desc[31:20], va[19:0]}, `rsp_is_section_o` = 1, `rsp_fault_o` = 0 and `rsp_desc_o` = that descriptor.
- R4: A first-level descriptor with bits [1:0] = 2'b01 is a coarse table pointer. The second read is at {desc[31:10], va[19:12], 2'b00}.
- R5: A second-level entry with bits [1:0] = 2'b10 is a 4KB small page. The walk returns pa = {entry[31:12], va[11:0]}, `rsp_is_section_o` = 0, `rsp_fault_o` = 0 and `rsp_desc_o` = that entry, after exactly two reads.
- R6: A first-level descriptor with bits [1:0] of 2'b00 or 2'b11 ends the walk with `rsp_fault_o` = 1 after one read.
- R7: A second-level entry with bits [1:0] of 2'b00, 2'b01 or 2'b11 ends the walk with `rsp_fault_o` = 1 after two reads.
- R8: On a fault, `rsp_iabort_o` equals the latched instruction flag and `rsp_dabort_o` is its complement. On success both are 0.
- R9: While `mem_req_o` is 1 and `mem_rvalid_i` is 0, `mem_req_o` stays 1 on the next cycle with `mem_addr_o` unchanged. A `mem_rvalid_i` pulse with no read outstanding has no effect.
- R10: `req_ready_o` is 1 only while idle. A request presented while a walk is in progress is not accepted.
- R11: `rsp_valid_o` is a single-cycle pulse per walk, carrying the values of the walk that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_i | input | 32 | First-level table base, sampled when a request is accepted |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_va_i | input | 32 | Virtual address to translate |
| req_is_instr_i | input | 1 | 1 for instruction fetch, 0 for data access |
| mem_req_o | output | 1 | Word read outstanding |
| mem_addr_o | output | 32 | Byte address of the word read |
| mem_rvalid_i | input | 1 | Read data valid, completes the outstanding read |
| mem_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Walk result valid, one cycle |
| rsp_pa_o | output | 32 | Translated physical address |
| rsp_is_section_o | output | 1 | 1 for a 1MB section, 0 for a 4KB page |
| rsp_desc_o | output | 32 | Raw final descriptor, attribute bits included |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_iabort_o | output | 1 | Fault on an instruction access |
| rsp_dabort_o | output | 1 | Fault on a data access |

## Verification
A wrong latched descriptor or a wrong decode shows at the ports within one or two reads. The second read lands at an unexpected address, or the response has the wrong size flag, address or fault. A lost state transition shows as a read request that never drops, or as a request accepted while a walk is still running. A corrupted latched access type shows only on faults, as the wrong abort line on the response pulse. The scoreboard records every read address and the read count for each walk, and compares them with a walk it computes from its own table model, so each error is caught at the response of the walk in which it occurs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW           = 32;
  localparam int L1_IDX_W     = 12;
  localparam int SEC_OFF_W    = AW - L1_IDX_W;          // 20
  localparam int PG_OFF_W     = 12;
  localparam int L2_IDX_W     = SEC_OFF_W - PG_OFF_W;   // 8
  localparam int TTB_ALIGN    = L1_IDX_W + 2;           // 14
  localparam int TTB_W        = AW - TTB_ALIGN;
  localparam int L2_BASE_LSB  = L2_IDX_W + 2;           // 10
  localparam int L2_BASE_W    = AW - L2_BASE_LSB;

  localparam logic [1:0] L1_CODE_SECTION = 2'b10;
  localparam logic [1:0] L1_CODE_COARSE  = 2'b01;
  localparam logic [1:0] L2_CODE_SMALL   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_RD, ST_L1_DEC, ST_L2_RD, ST_L2_DEC, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    K_FAULT, K_SECTION, K_COARSE, K_SMALL
  } desc_kind_e;
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic       lvl2_i,
  output desc_kind_e kind_o
);
  always_comb begin
    kind_o = K_FAULT;
    if (lvl2_i) begin
      if (code_i == L2_CODE_SMALL) kind_o = K_SMALL;
    end else begin
      unique case (code_i)
        L1_CODE_SECTION: kind_o = K_SECTION;
        L1_CODE_COARSE:  kind_o = K_COARSE;
        default:         kind_o = K_FAULT;   // invalid or unsupported fine table
      endcase
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [TTB_W-1:0]     ttb_hi_i,
  input  logic [AW-1:0]        va_i,
  input  logic [L2_BASE_W-1:0] desc_hi_i,
  input  logic                 lvl2_i,
  output logic [AW-1:0]        rd_addr_o,
  output logic [AW-1:0]        sec_pa_o,
  output logic [AW-1:0]        page_pa_o
);
  logic [AW-1:0] l1_addr, l2_addr;

  assign l1_addr   = {ttb_hi_i, va_i[AW-1 -: L1_IDX_W], 2'b00};
  assign l2_addr   = {desc_hi_i, va_i[SEC_OFF_W-1:PG_OFF_W], 2'b00};
  assign rd_addr_o = lvl2_i ? l2_addr : l1_addr;

  assign sec_pa_o  = {desc_hi_i[L2_BASE_W-1 -: L1_IDX_W], va_i[SEC_OFF_W-1:0]};
  assign page_pa_o = {desc_hi_i[L2_BASE_W-1 -: (AW-PG_OFF_W)], va_i[PG_OFF_W-1:0]};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_va_i,
  input  logic             req_is_instr_i,
  input  logic [TTB_W-1:0] ttb_hi_i,
  output logic             mem_req_o,
  input  logic [AW-1:0]    mem_addr_i,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  input  desc_kind_e       kind_i,
  input  logic [AW-1:0]    sec_pa_i,
  input  logic [AW-1:0]    page_pa_i,
  output logic [AW-1:0]    va_o,
  output logic [AW-1:0]    desc_o,
  output logic [TTB_W-1:0] ttb_o,
  output logic             lvl2_rd_o,
  output logic             lvl2_dec_o,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic             rsp_is_section_o,
  output logic             rsp_iabort_o,
  output logic             rsp_dabort_o,
  output logic [AW-1:0]    rsp_pa_o
);
  walk_state_e      state_q, state_d;
  logic [AW-1:0]    va_q, desc_q, pa_q;
  logic [TTB_W-1:0] ttb_q;
  logic             instr_q, sect_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_L1_RD;
      ST_L1_RD:  if (mem_rvalid_i) state_d = ST_L1_DEC;
      ST_L1_DEC: begin
        unique case (kind_i)
          K_SECTION: state_d = ST_DONE;
          K_COARSE:  state_d = ST_L2_RD;
          default:   state_d = ST_FAULT;
        endcase
      end
      ST_L2_RD:  if (mem_rvalid_i) state_d = ST_L2_DEC;
      ST_L2_DEC: state_d = (kind_i == K_SMALL) ? ST_DONE : ST_FAULT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      desc_q  <= '0;
      pa_q    <= '0;
      ttb_q   <= '0;
      instr_q <= 1'b0;
      sect_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        va_q    <= req_va_i;
        instr_q <= req_is_instr_i;
        ttb_q   <= ttb_hi_i;
      end
      if ((state_q == ST_L1_RD || state_q == ST_L2_RD) && mem_rvalid_i)
        desc_q <= mem_rdata_i;
      if (state_q == ST_L1_DEC && kind_i == K_SECTION) begin
        pa_q   <= sec_pa_i;
        sect_q <= 1'b1;
      end
      if (state_q == ST_L2_DEC && kind_i == K_SMALL) begin
        pa_q   <= page_pa_i;
        sect_q <= 1'b0;
      end
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign mem_req_o        = (state_q == ST_L1_RD) || (state_q == ST_L2_RD);
  assign lvl2_rd_o        = (state_q == ST_L2_RD);
  assign lvl2_dec_o       = (state_q == ST_L2_DEC);
  assign va_o             = va_q;
  assign desc_o           = desc_q;
  assign ttb_o            = ttb_q;
  assign rsp_valid_o      = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o      = (state_q == ST_FAULT);
  assign rsp_is_section_o = sect_q;
  assign rsp_pa_o         = pa_q;
  assign rsp_iabort_o     = rsp_fault_o && instr_q;
  assign rsp_dabort_o     = rsp_fault_o && !instr_q;

  a_r9_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_i)));

  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r8_abort_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_iabort_o, rsp_dabort_o}) == (rsp_fault_o ? 1 : 0)));

  a_r9_va_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !rsp_valid_o) |=> $stable(va_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   ttb_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_va_i,
  input  logic          req_is_instr_i,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_pa_o,
  output logic          rsp_is_section_o,
  output logic [31:0]   rsp_desc_o,
  output logic          rsp_fault_o,
  output logic          rsp_iabort_o,
  output logic          rsp_dabort_o
);
  logic [AW-1:0]    va_w, desc_w, sec_pa_w, page_pa_w;
  logic [TTB_W-1:0] ttb_w;
  logic             lvl2_rd_w, lvl2_dec_w;
  desc_kind_e       kind_w;
  logic             unused_ttb_lo;

  assign unused_ttb_lo = ^ttb_i[TTB_ALIGN-1:0];

  ptw_ctrl u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_va_i         (req_va_i),
    .req_is_instr_i   (req_is_instr_i),
    .ttb_hi_i         (ttb_i[AW-1:TTB_ALIGN]),
    .mem_req_o        (mem_req_o),
    .mem_addr_i       (mem_addr_o),
    .mem_rvalid_i     (mem_rvalid_i),
    .mem_rdata_i      (mem_rdata_i),
    .kind_i           (kind_w),
    .sec_pa_i         (sec_pa_w),
    .page_pa_i        (page_pa_w),
    .va_o             (va_w),
    .desc_o           (desc_w),
    .ttb_o            (ttb_w),
    .lvl2_rd_o        (lvl2_rd_w),
    .lvl2_dec_o       (lvl2_dec_w),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_fault_o      (rsp_fault_o),
    .rsp_is_section_o (rsp_is_section_o),
    .rsp_iabort_o     (rsp_iabort_o),
    .rsp_dabort_o     (rsp_dabort_o),
    .rsp_pa_o         (rsp_pa_o)
  );

  ptw_desc_decode u_dec (
    .code_i (desc_w[1:0]),
    .lvl2_i (lvl2_dec_w),
    .kind_o (kind_w)
  );

  ptw_addr_gen u_agen (
    .ttb_hi_i  (ttb_w),
    .va_i      (va_w),
    .desc_hi_i (desc_w[AW-1:L2_BASE_LSB]),
    .lvl2_i    (lvl2_rd_w),
    .rd_addr_o (mem_addr_o),
    .sec_pa_o  (sec_pa_w),
    .page_pa_o (page_pa_w)
  );

  assign rsp_desc_o = desc_w;
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ttb_i = 32'h0004_3ABC;  // low 14 bits garbage (R2)
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic        req_is_instr_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_pa_o;
  logic        rsp_is_section_o;
  logic [31:0] rsp_desc_o;
  logic        rsp_fault_o, rsp_iabort_o, rsp_dabort_o;

  always #4 clk_i = ~clk_i;

  pt_walker dut_i (.*);

  typedef struct {
    logic [31:0] pa;
    logic        sect;
    logic        fault;
    logic        iab;
    logic        dab;
    logic [31:0] desc;
    int          reads;
    logic [31:0] a1;
    logic [31:0] a2;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mem [logic [31:0]];
  int          n_chk = 0, n_fail = 0;
  int          lat_cfg = 0;
  int          n_reads = 0;
  logic [31:0] addr_log [2];
  bit          stray_req = 0;
  bit          done = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial forever begin
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    if (mem_req_o) begin
      repeat (lat_cfg) @(negedge clk_i);
      if (n_reads < 2) addr_log[n_reads] = mem_addr_o;
      n_reads++;
      mem_rdata_i  = rd(mem_addr_o);
      mem_rvalid_i = 1'b1;
    end else if (stray_req) begin
      stray_req    = 0;
      mem_rdata_i  = 32'h00F0_0002;
      mem_rvalid_i = 1'b1;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk_i);
    if (rsp_valid_o) begin
      if (q.size() == 0) begin
        chk(0, "R11 unexpected response", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(addr_log[0] == e.a1, {"R2 first read addr ", e.tag}, addr_log[0], e.a1);
        if (e.reads == 2) chk(addr_log[1] == e.a2, {"R4 second read addr ", e.tag}, addr_log[1], e.a2);
        chk(n_reads == e.reads, {e.tag, " read count"}, n_reads, e.reads);
        chk(rsp_fault_o == e.fault, {e.tag, " fault"}, {31'b0, rsp_fault_o}, {31'b0, e.fault});
        chk({rsp_iabort_o, rsp_dabort_o} == {e.iab, e.dab}, {"R8 abort kind ", e.tag},
            {30'b0, rsp_iabort_o, rsp_dabort_o}, {30'b0, e.iab, e.dab});
        if (!e.fault) begin
          chk(rsp_pa_o == e.pa, {e.tag, " pa"}, rsp_pa_o, e.pa);
          chk(rsp_is_section_o == e.sect, {e.tag, " size"}, {31'b0, rsp_is_section_o}, {31'b0, e.sect});
          chk(rsp_desc_o == e.desc, {e.tag, " desc"}, rsp_desc_o, e.desc);
        end
        @(negedge clk_i);
        chk(!rsp_valid_o && req_ready_o, "R11 pulse ends, walker idle", {31'b0, rsp_valid_o}, 32'h0);
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic instr, input int lat, input bit stray);
    exp_t        e;
    logic [31:0] d1, d2;
    e.a1 = {ttb_i[31:14], va[31:20], 2'b00};
    d1 = rd(e.a1);
    e.a2 = '0; e.pa = '0; e.sect = 0; e.desc = d1;
    if (d1[1:0] == 2'b10) begin
      e.reads = 1; e.fault = 0; e.sect = 1; e.pa = {d1[31:20], va[19:0]}; e.tag = "R3";
    end else if (d1[1:0] == 2'b01) begin
      e.reads = 2;
      e.a2 = {d1[31:10], va[19:12], 2'b00};
      d2 = rd(e.a2);
      e.desc = d2;
      if (d2[1:0] == 2'b10) begin
        e.fault = 0; e.pa = {d2[31:12], va[11:0]}; e.tag = "R5";
      end else begin
        e.fault = 1; e.tag = "R7";
      end
    end else begin
      e.reads = 1; e.fault = 1; e.tag = "R6";
    end
    e.iab = e.fault && instr;
    e.dab = e.fault && !instr;
    q.push_back(e);
    lat_cfg = lat;
    @(negedge clk_i);
    if (stray) begin
      stray_req = 1;
      repeat (3) @(negedge clk_i);
      chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R9 stray rvalid ignored",
          {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);
    end
    n_reads = 0;
    req_valid_i = 1'b1; req_va_i = va; req_is_instr_i = instr;
    @(negedge clk_i);
    chk(!req_ready_o, "R10 not ready while walking", {31'b0, req_ready_o}, 32'h0);
    req_va_i = ~va; req_is_instr_i = ~instr;  // held request must be ignored
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait (q.size() == 0);
    repeat (3) @(negedge clk_i);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      chk(0, "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // L1 at 0x0004_0000, coarse table at 0x0008_0400
    mem[32'h0004_0000 + 32'h123*4] = 32'hABC0_0C12;  // section
    mem[32'h0004_0000 + 32'hFFF*4] = 32'h0010_0002;  // section at top index
    mem[32'h0004_0000 + 32'h456*4] = 32'h0008_0401;  // coarse
    mem[32'h0004_0000 + 32'h789*4] = 32'h1234_5673;  // fine: unsupported
    mem[32'h0008_0400 + 32'h78*4]  = 32'h7654_3FFE;  // small page
    mem[32'h0008_0400 + 32'h01*4]  = 32'h1111_1001;  // large: unsupported
    mem[32'h0008_0400 + 32'h02*4]  = 32'h2222_2003;  // tiny: unsupported
    mem[32'h0008_0400 + 32'hFF*4]  = 32'hFFFF_F00E;  // small page, last entry

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1 ready after reset", {31'b0, req_ready_o}, 32'h1);
    chk(mem_req_o == 1'b0, "R1 no read in reset", {31'b0, mem_req_o}, 32'h0);
    chk(rsp_valid_o == 1'b0, "R1 no response in reset", {31'b0, rsp_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1 idle after reset release",
        {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);

    walk(32'h1234_5678, 1'b0, 0, 0);  // R3
    walk(32'hFFFF_FFFF, 1'b1, 2, 0);  // R3 top index
    walk(32'h4567_89AB, 1'b0, 1, 0);  // R4 R5
    walk(32'h456F_F123, 1'b1, 3, 1);  // R5 last entry, R9 stray
    walk(32'h4560_0123, 1'b0, 0, 0);  // R7 code 00, data abort
    walk(32'h4560_1FFF, 1'b1, 2, 0);  // R7 code 01, instr abort
    walk(32'h4560_2000, 1'b0, 1, 1);  // R7 code 11
    walk(32'h0000_0000, 1'b1, 0, 0);  // R6 code 00, instr
    walk(32'h0001_0000, 1'b0, 3, 0);  // R6 code 00, data
    walk(32'h789A_BCDE, 1'b1, 1, 0);  // R6 code 11
    ttb_i = 32'h0004_0001;            // R2 other low bits
    walk(32'h1230_0000, 1'b0, 2, 0);
    walk(32'h4567_8000, 1'b1, 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule